// File: doc/BRIEF.md
# Capture/Compare Timer Unit

A 16-bit free-running counter with four input-capture channels and three compare registers. The compare registers drive eight timed output pins. The counter advances on a tick from an internal prescaler or on rising edges of an external event input. A rising edge on a dedicated reset input returns the counter to zero.

Each capture channel watches its own input, synchronised through two flops. On the edge it is set to watch, the channel stores the counter value and raises a sticky flag. Compare registers 0 and 1 set or reset six level outputs, each through its own pair of masks. Compare register 2 toggles two outputs through an enable mask.

A compare register is tested only in the cycle after the counter increments, so one count value produces at most one event. A host loads the configuration through a single-cycle write port and reads the captured values and the flags directly.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, all capture values, all flags and all eight timed outputs are zero.
- R2: Register 0 holds the run enable in bit 0, the source select in bit 1 (1 = external event) and the divider in bits 15:8. When run is set with the internal source, the counter advances once every divider+1 clock cycles. When run is set with the external source, it advances once per rising edge of `evt_i`. When run is clear, the counter holds its value.
- R3: A rising edge on `ext_rst_i` clears the counter and the prescaler. This clearing produces no compare event.
- R4: The overflow flag is set when an increment takes the counter from 0xFFFF to 0x0000.
- R5: Register 1 holds a 2-bit edge mode for capture channel i at bits [2i+1:2i]. The codes are 0 = off, 1 = rising, 2 = falling and 3 = both. On a selected edge the channel latches the counter value and sets its flag. A channel whose mode is off ignores its input.
- R6: Compare values 0, 1 and 2 are written at addresses 2, 3 and 4. For compare 0, the set mask is at address 5 and the reset mask at address 6. For compare 1, the set mask is at address 7 and the reset mask at address 8. On a match, the outputs `sr_o` selected by a set mask go high and those selected by a reset mask go low. When an output is both set and reset in the same cycle, the reset wins.
- R7: A compare 2 match inverts each `tgl_o` bit enabled in the mask at address 9.
- R8: A compare is evaluated only on the counter value just after an increment. A match sets compare flag k and updates the outputs one cycle after the counter changes. A counter that holds its value produces no repeat event.
- R9: A write to address 10 clears flags where the data bit is 1. Bits 3:0 map to the capture flags, bit 4 to the overflow flag and bits 7:5 to compare flags 0 to 2. Flags whose data bit is 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | External count event |
| ext_rst_i | input | 1 | Counter clear, rising-edge acting |
| cap_i | input | 4 | Capture inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Counter value |
| cap_val_o | output | 64 | Capture values, channel i at bits [16i+15:16i] |
| cap_flag_o | output | 4 | Capture flags |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 3 | Compare match flags |
| sr_o | output | 6 | Set/reset timed outputs |
| tgl_o | output | 2 | Toggle timed outputs |

## Verification
The assertions assume that the counter leaves its value only by a single increment or by a return to zero. They also assume that a counter arriving at zero by an external clear is not treated as a match. For that reason, the set/reset property excludes a match at zero. The stimulus holds each event, reset and capture pulse well beyond the two synchronising flops. It changes the compare configuration only while the counter is stopped between events. Captures are made while the counter is frozen in event mode, so each latched value is known exactly.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int REG_AW = 4;
  localparam int N_CMP  = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 4'd0;
  localparam logic [REG_AW-1:0] A_EDGE = 4'd1;
  localparam logic [REG_AW-1:0] A_CMP0 = 4'd2;
  localparam logic [REG_AW-1:0] A_CMP1 = 4'd3;
  localparam logic [REG_AW-1:0] A_CMP2 = 4'd4;
  localparam logic [REG_AW-1:0] A_SET0 = 4'd5;
  localparam logic [REG_AW-1:0] A_RST0 = 4'd6;
  localparam logic [REG_AW-1:0] A_SET1 = 4'd7;
  localparam logic [REG_AW-1:0] A_RST1 = 4'd8;
  localparam logic [REG_AW-1:0] A_TGLE = 4'd9;
  localparam logic [REG_AW-1:0] A_CLR  = 4'd10;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/capcmp_count.sv
module capcmp_count #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             src_ext_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             evt_i,
  input  logic             ext_rst_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o,
  output logic             ovf_flag_o
);
  logic evt_rise, evt_fall, clr_rise, clr_fall;
  logic [DIV_W-1:0] pc_q;
  logic tick;

  capcmp_sync u_evt_sync (.clk_i, .rst_ni, .d_i(evt_i),     .rise_o(evt_rise), .fall_o(evt_fall));
  capcmp_sync u_clr_sync (.clk_i, .rst_ni, .d_i(ext_rst_i), .rise_o(clr_rise), .fall_o(clr_fall));

  assign tick = run_i & (src_ext_i ? evt_rise : (pc_q == div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      cnt_o      <= '0;
      inc_o      <= 1'b0;
      ovf_flag_o <= 1'b0;
    end else begin
      if (clr_rise || !run_i || src_ext_i || pc_q == div_i) pc_q <= '0;
      else                                                  pc_q <= pc_q + 1'b1;

      if (clr_rise)  cnt_o <= '0;
      else if (tick) cnt_o <= cnt_o + 1'b1;

      inc_o      <= tick & ~clr_rise;
      // set wins over a same-cycle clear
      ovf_flag_o <= (ovf_flag_o & ~ovf_clr_i) | (tick & ~clr_rise & (&cnt_o));
    end
  end

  logic unused_fall;
  assign unused_fall = evt_fall ^ clr_fall;
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture import capcmp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  edge_sel_e        mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o
);
  logic rise, fall, hit;

  capcmp_sync u_sync (.clk_i, .rst_ni, .d_i(cap_i), .rise_o(rise), .fall_o(fall));

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (hit) val_o <= cnt_i;
      flag_o <= (flag_o & ~clr_i) | hit;
    end
  end
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match import capcmp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_SR  = 6,
  parameter int N_TGL = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic                        inc_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  input  logic [N_SR-1:0]             set0_i,
  input  logic [N_SR-1:0]             rst0_i,
  input  logic [N_SR-1:0]             set1_i,
  input  logic [N_SR-1:0]             rst1_i,
  input  logic [N_TGL-1:0]            tgl_en_i,
  input  logic [N_CMP-1:0]            clr_i,
  output logic [N_SR-1:0]             sr_o,
  output logic [N_TGL-1:0]            tgl_o,
  output logic [N_CMP-1:0]            flag_o
);
  logic [N_CMP-1:0] hit;
  logic [N_SR-1:0]  set_req, rst_req;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign hit[k] = inc_i & (cnt_i == cmp_i[k]);
  end

  assign set_req = ({N_SR{hit[0]}} & set0_i) | ({N_SR{hit[1]}} & set1_i);
  assign rst_req = ({N_SR{hit[0]}} & rst0_i) | ({N_SR{hit[1]}} & rst1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o   <= '0;
      tgl_o  <= '0;
      flag_o <= '0;
    end else begin
      sr_o   <= (sr_o | set_req) & ~rst_req;
      tgl_o  <= tgl_o ^ ({N_TGL{hit[2]}} & tgl_en_i);
      flag_o <= (flag_o & ~clr_i) | hit;
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer import capcmp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4,
  parameter int N_SR  = 6,
  parameter int N_TGL = 2,
  parameter int DIV_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   evt_i,
  input  logic                   ext_rst_i,
  input  logic [N_CAP-1:0]       cap_i,
  input  logic                   wr_en_i,
  input  logic [REG_AW-1:0]      wr_addr_i,
  input  logic [CNT_W-1:0]       wr_data_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [N_CAP*CNT_W-1:0] cap_val_o,
  output logic [N_CAP-1:0]       cap_flag_o,
  output logic                   ovf_flag_o,
  output logic [N_CMP-1:0]       cmp_flag_o,
  output logic [N_SR-1:0]        sr_o,
  output logic [N_TGL-1:0]       tgl_o
);
  localparam int CLR_W   = N_CAP + 1 + N_CMP;
  localparam int OVF_BIT = N_CAP;
  localparam int CMP_LSB = N_CAP + 1;

  logic                        run_q, src_q;
  logic [DIV_W-1:0]            div_q;
  logic [2*N_CAP-1:0]          edge_q;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [N_SR-1:0]             set0_q, rst0_q, set1_q, rst1_q;
  logic [N_TGL-1:0]            tgl_en_q;
  logic [CLR_W-1:0]            clr;
  logic                        inc;

  assign clr = (wr_en_i && wr_addr_i == A_CLR) ? wr_data_i[CLR_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      src_q    <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      cmp_q    <= '0;
      set0_q   <= '0;
      rst0_q   <= '0;
      set1_q   <= '0;
      rst1_q   <= '0;
      tgl_en_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL: begin
          run_q <= wr_data_i[0];
          src_q <= wr_data_i[1];
          div_q <= wr_data_i[DIV_W+7:8];
        end
        A_EDGE: edge_q   <= wr_data_i[2*N_CAP-1:0];
        A_CMP0: cmp_q[0] <= wr_data_i;
        A_CMP1: cmp_q[1] <= wr_data_i;
        A_CMP2: cmp_q[2] <= wr_data_i;
        A_SET0: set0_q   <= wr_data_i[N_SR-1:0];
        A_RST0: rst0_q   <= wr_data_i[N_SR-1:0];
        A_SET1: set1_q   <= wr_data_i[N_SR-1:0];
        A_RST1: rst1_q   <= wr_data_i[N_SR-1:0];
        A_TGLE: tgl_en_q <= wr_data_i[N_TGL-1:0];
        default: ;
      endcase
    end
  end

  capcmp_count #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_count (
    .clk_i, .rst_ni,
    .run_i(run_q), .src_ext_i(src_q), .div_i(div_q),
    .evt_i, .ext_rst_i, .ovf_clr_i(clr[OVF_BIT]),
    .cnt_o, .inc_o(inc), .ovf_flag_o
  );

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    capcmp_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni,
      .cap_i(cap_i[g]),
      .mode_i(edge_sel_e'(edge_q[2*g +: 2])),
      .cnt_i(cnt_o),
      .clr_i(clr[g]),
      .val_o(cap_val_o[g*CNT_W +: CNT_W]),
      .flag_o(cap_flag_o[g])
    );
  end

  capcmp_match #(.CNT_W(CNT_W), .N_SR(N_SR), .N_TGL(N_TGL)) u_match (
    .clk_i, .rst_ni,
    .cnt_i(cnt_o), .inc_i(inc), .cmp_i(cmp_q),
    .set0_i(set0_q), .rst0_i(rst0_q), .set1_i(set1_q), .rst1_i(rst1_q),
    .tgl_en_i(tgl_en_q),
    .clr_i(clr[CMP_LSB +: N_CMP]),
    .sr_o, .tgl_o, .flag_o(cmp_flag_o)
  );
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk import capcmp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4,
  parameter int N_SR  = 6,
  parameter int N_TGL = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [CNT_W-1:0]            cnt_o,
  input logic [N_CAP*CNT_W-1:0]      cap_val_o,
  input logic [N_CAP-1:0]            cap_flag_o,
  input logic                        ovf_flag_o,
  input logic [N_SR-1:0]             sr_o,
  input logic [N_TGL-1:0]            tgl_o,
  input logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  input logic [N_SR-1:0]             rst0_i,
  input logic [N_SR-1:0]             rst1_i
);
  logic [CNT_W-1:0] cnt_prev;
  logic             prev_vld;
  logic             stepped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_prev <= '0;
      prev_vld <= 1'b0;
    end else begin
      cnt_prev <= cnt_o;
      prev_vld <= 1'b1;
    end
  end

  assign stepped = prev_vld && (cnt_o == cnt_prev + 1'b1) && (cnt_o != '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld && cnt_o != cnt_prev) |-> (cnt_o == cnt_prev + 1'b1 || cnt_o == '0));

  // R4
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> (cnt_o == '0 && $past(cnt_o) == '1));

  // R6
  rst0_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stepped && cnt_o == cmp_i[0]) |=> ((sr_o & $past(rst0_i)) == '0));

  // R6
  rst1_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stepped && cnt_o == cmp_i[1]) |=> ((sr_o & $past(rst1_i)) == '0));

  // R7
  tgl_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_o != $past(tgl_o)) |-> ($past(cnt_o) == $past(cmp_i[2]) && $past(cnt_o) != $past(cnt_prev)));

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap_chk
    // R5
    cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cap_flag_o[i]) |-> (cap_val_o[i*CNT_W +: CNT_W] == $past(cnt_o)));
  end
endmodule

bind capcmp_timer capcmp_timer_chk #(
  .CNT_W(CNT_W), .N_CAP(N_CAP), .N_SR(N_SR), .N_TGL(N_TGL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt_o), .cap_val_o(cap_val_o),
  .cap_flag_o(cap_flag_o), .ovf_flag_o(ovf_flag_o), .sr_o(sr_o), .tgl_o(tgl_o),
  .cmp_i(cmp_q), .rst0_i(rst0_q), .rst1_i(rst1_q)
);

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0, ext_rst = 1'b0;
  logic [3:0]  cap = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic [63:0] cap_val;
  logic [3:0]  cap_flag;
  logic        ovf_flag;
  logic [2:0]  cmp_flag;
  logic [5:0]  sr;
  logic [1:0]  tgl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt, c0, c1, c2;
  logic [5:0]  m_sr, s0, r0, s1, r1;
  logic [1:0]  m_tgl, te;
  logic [2:0]  m_cf;
  logic [15:0] m_val [4];

  always #(CYC/2) clk = ~clk;

  capcmp_timer u_capcmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ext_rst_i(ext_rst), .cap_i(cap),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .cap_val_o(cap_val), .cap_flag_o(cap_flag), .ovf_flag_o(ovf_flag),
    .cmp_flag_o(cmp_flag), .sr_o(sr), .tgl_o(tgl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
    tick(1);
  endtask

  task automatic evt_pulse();
    evt = 1'b1; tick(6);
    evt = 1'b0; tick(4);
  endtask

  task automatic cfg(input logic [15:0] a0, a1, a2, input logic [5:0] as0, ar0, as1, ar1,
                     input logic [1:0] ate);
    c0 = a0; c1 = a1; c2 = a2; s0 = as0; r0 = ar0; s1 = as1; r1 = ar1; te = ate;
    wr(4'd2, c0); wr(4'd3, c1); wr(4'd4, c2);
    wr(4'd5, {10'd0, s0}); wr(4'd6, {10'd0, r0});
    wr(4'd7, {10'd0, s1}); wr(4'd8, {10'd0, r1});
    wr(4'd9, {14'd0, te});
  endtask

  // one event, model per R6/R7/R8
  task automatic step_chk();
    logic h0, h1, h2;
    evt_pulse();
    m_cnt = m_cnt + 1'b1;
    h0 = (m_cnt == c0); h1 = (m_cnt == c1); h2 = (m_cnt == c2);
    m_sr  = (m_sr | ({6{h0}} & s0) | ({6{h1}} & s1)) & ~(({6{h0}} & r0) | ({6{h1}} & r1));
    m_tgl = m_tgl ^ ({2{h2}} & te);
    m_cf  = m_cf | {h2, h1, h0};
    chk("R2 event count", cnt, m_cnt);
    chk("R6 set/reset outputs", sr, m_sr);
    chk("R7 toggle outputs", tgl, m_tgl);
    chk("R8 compare flags", cmp_flag, m_cf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1
    chk("R1 counter", cnt, 0);
    chk("R1 capture values", cap_val[31:0] | cap_val[63:32], 0);
    chk("R1 flags", {cap_flag, ovf_flag, cmp_flag}, 0);
    chk("R1 outputs", {sr, tgl}, 0);

    m_cnt = 0; m_sr = 0; m_tgl = 0; m_cf = 0;
    for (int i = 0; i < 4; i++) m_val[i] = 0;

    // events while stopped: counter holds (R2)
    evt_pulse();
    chk("R2 stopped hold", cnt, 0);

    wr(4'd0, 16'h0003);
    cfg(16'd5, 16'd9, 16'd3, 6'b001111, 6'b000000, 6'b000000, 6'b000101, 2'b01);
    for (int k = 0; k < 12; k++) step_chk();
    // coincident match: reset of bit 4 must win (R6)
    cfg(16'd15, 16'd15, 16'd14, 6'b110000, 6'b000000, 6'b000000, 6'b010000, 2'b11);
    for (int k = 0; k < 6; k++) step_chk();

    // R3: clear to zero with compare values at zero gives no event
    cfg(16'd0, 16'd0, 16'd0, 6'b111111, 6'b000000, 6'b000000, 6'b000000, 2'b11);
    ext_rst = 1'b1; tick(6); ext_rst = 1'b0; tick(4);
    m_cnt = 0;
    chk("R3 cleared counter", cnt, 0);
    chk("R3 no set event", sr, m_sr);
    chk("R3 no toggle event", tgl, m_tgl);
    chk("R3 no compare flag", cmp_flag, m_cf);

    // R9: partial write-one-to-clear
    wr(4'd10, 16'h0020);
    m_cf[0] = 1'b0;
    chk("R9 partial clear", cmp_flag, m_cf);
    wr(4'd10, 16'h00C0);
    m_cf = 0;
    chk("R9 clear rest", cmp_flag, 0);
    cfg(16'hF000, 16'hF000, 16'hF000, 6'd0, 6'd0, 6'd0, 6'd0, 2'd0);

    // R5: every edge mode on all channels, counter frozen between events
    for (int sel = 0; sel < 4; sel++) begin
      logic [1:0] s;
      logic exp_r, exp_f;
      s = 2'(sel);
      exp_r = (sel == 1 || sel == 3);
      exp_f = (sel == 2 || sel == 3);
      wr(4'd1, {8'd0, {4{s}}});
      wr(4'd10, 16'h000F);
      step_chk();
      cap = 4'hF; tick(6);
      if (exp_r) for (int i = 0; i < 4; i++) m_val[i] = m_cnt;
      chk("R5 rising flags", cap_flag, exp_r ? 4'hF : 4'h0);
      for (int i = 0; i < 4; i++) chk("R5 rising value", cap_val[16*i +: 16], m_val[i]);
      wr(4'd10, 16'h000F);
      step_chk();
      cap = 4'h0; tick(6);
      if (exp_f) for (int i = 0; i < 4; i++) m_val[i] = m_cnt;
      chk("R5 falling flags", cap_flag, exp_f ? 4'hF : 4'h0);
      for (int i = 0; i < 4; i++) chk("R5 falling value", cap_val[16*i +: 16], m_val[i]);
    end
    // R9 on capture flags: clear channels 0 and 2 only
    wr(4'd10, 16'h0005);
    chk("R9 capture partial clear", cap_flag, 4'hA);

    // R2 internal source, divider 0: +1 each cycle
    wr(4'd10, 16'h00FF);
    wr(4'd0, 16'h0001);
    for (int k = 0; k < 100; k++) begin
      logic [15:0] p;
      p = cnt; tick(1);
      chk("R2 internal step", cnt, p + 16'd1);
    end
    // R4 overflow at wrap
    for (int k = 0; k < 70000 && cnt != 16'hFFFF; k++) tick(1);
    chk("R4 flag before wrap", {cnt, 15'd0, ovf_flag}, {16'hFFFF, 16'd0});
    tick(1);
    chk("R4 wrapped counter", cnt, 0);
    chk("R4 flag after wrap", ovf_flag, 1);
    wr(4'd10, 16'h0010);
    chk("R9 overflow clear", ovf_flag, 0);

    // R2 divider 3: one step every 4 cycles
    wr(4'd0, 16'h0301);
    for (int k = 0; k < 5; k++) begin
      int n;
      logic [15:0] p;
      n = 0; p = cnt;
      while (cnt == p && n < 20) begin tick(1); n++; end
      if (k > 0) chk("R2 prescaler gap", n, 4);
    end

    // R2 run cleared: counter holds
    wr(4'd0, 16'h0000);
    tick(2);
    begin
      logic [15:0] v;
      v = cnt; tick(20);
      chk("R2 halted", cnt, v);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule